// File: doc/BRIEF.md
# Interleaved Base-Stride Address Generator

This block produces SRAM read addresses for the two operand streams of a matrix inner-product kernel that keeps several inner products in flight at once. Both matrices are stored row-major. The first operand is read along a row of the left matrix. The second operand is read down a column of the right matrix using a base-plus-stride pattern. A long-latency accumulator needs a new product only once every few cycles. To keep it busy, the kernel interleaves a group of neighbouring columns. On each advance the generator serves the next inner product in the group.

The column stream emits one base-stride walk per slot, round-robin. Each walk starts at the column base plus a programmable start offset, which selects the column group, plus the slot number. The walk is then stepped by the inner-loop element index times the row stride. The row stream follows the enclosing outer-loop counter (the row index) and the same element index. Its address therefore stays the same for every slot of a group, so one row element serves all interleaved inner products. Each address leaves a register together with a valid flag. The column address also carries its slot tag and a last-slot flag, which the loop unit uses to step the element index.

The interleave factor can be set anywhere from one up to a built-in maximum. A smaller value serves a remainder group of columns, for example two columns left over at the edge of a matrix.

Top module: `ilv_addr_gen`

## Requirements
- R1: After reset, both valid outputs are 0 and both addresses, the slot tag and the last flag are 0. The effective interleave factor is 1, so the first advance yields tag 0 with the last flag set.
- R2: One clock after an advance, row_addr = row_base + outer_cnt*stride + inner_cnt, taken modulo 2^ADDR_W, and row_valid = 1.
- R3: While outer_cnt and inner_cnt do not change, row_addr is identical for every slot of an interleave group.
- R4: One clock after an advance, col_addr = col_base + offset + slot + inner_cnt*stride, taken modulo 2^ADDR_W, and col_valid = 1.
- R5: The slot tag takes the values 0, 1, ..., F-1 on successive advances, where F is the effective interleave factor, and then wraps to 0. col_last is 1 exactly when the tag equals F-1.
- R6: In a cycle where advance is 0 and no configuration is loaded, the block does not change state. Both valid flags are 0 on the next cycle, the addresses, tag and last flag hold their values, and the next advance continues with the following slot.
- R7: cfg_load captures the row base, column base, stride, offset and interleave factor, and resets the slot to 0. It takes priority over advance: no address is produced in that cycle, and both valid flags are 0 on the next cycle.
- R8: An interleave request of 0 is treated as 1. A request above MAX_ILV is treated as MAX_ILV.
- R9: A reduced interleave factor, such as 2 for a remainder group, cycles only over its own slots, and its column addresses follow R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Capture the configuration fields |
| cfg_row_base | input | ADDR_W | Base address of the row-read matrix |
| cfg_col_base | input | ADDR_W | Base address of the column-read matrix |
| cfg_stride | input | ADDR_W | Row stride (elements per row) |
| cfg_offset | input | ADDR_W | Start offset of the column group |
| cfg_ilv | input | ILV_W | Requested interleave factor |
| outer_cnt | input | CNT_W | Outer loop counter (row index) |
| inner_cnt | input | CNT_W | Inner loop counter (element index) |
| advance | input | 1 | Loop-unit strobe: produce the next address pair |
| row_addr | output | ADDR_W | Row stream address |
| row_valid | output | 1 | Row address produced in the previous cycle |
| col_addr | output | ADDR_W | Column stream address |
| col_valid | output | 1 | Column address produced in the previous cycle |
| col_tag | output | SLOT_W | Interleave slot of the column address |
| col_last | output | 1 | Column address belongs to the last slot of the group |

## Verification
Assertions check every cycle that the slot stays below the effective interleave factor and that the stored factor stays in range. They also check that the slot holds during stalls and returns to zero on a load, that consecutive valid tags increase by one, and that the last flag agrees with the tag. Only the bench scenarios can show that the address arithmetic is right. That covers the row address repeating across a group, the column offset per slot, clamping of the requested factor, and a remainder group with a factor of two. The bench compares these against values computed from the configuration and the loop counters.

// File: rtl/ilvag_pkg.sv
// Package: shared helpers for the interleaved address generator.
// Assumes callers pass widths already zero-extended to 32 bits.
package ilvag_pkg;

    // Limit a requested interleave factor to the range 1..max_f.
    function automatic int unsigned clamp_ilv(int unsigned req, int unsigned max_f);
        if (req == 0)
            return 1;
        else if (req > max_f)
            return max_f;
        else
            return req;
    endfunction

endpackage

// File: rtl/ilvag_cfg_regs.sv
// Configuration register bank. It captures the bases, stride, offset and
// interleave factor on load, and clamps the factor to 1..MAX_ILV.
// Assumes load is a single-cycle strobe from the control side.
module ilvag_cfg_regs #(
    parameter int ADDR_W  = 16,
    parameter int MAX_ILV = 7,
    parameter int ILV_W   = $clog2(MAX_ILV) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] row_base_in,
    input  logic [ADDR_W-1:0] col_base_in,
    input  logic [ADDR_W-1:0] stride_in,
    input  logic [ADDR_W-1:0] offset_in,
    input  logic [ILV_W-1:0]  ilv_in,
    output logic [ADDR_W-1:0] row_base,
    output logic [ADDR_W-1:0] col_start,
    output logic [ADDR_W-1:0] stride,
    output logic [ILV_W-1:0]  ilv_eff
);
    import ilvag_pkg::*;

    logic [ADDR_W-1:0] col_base_q;
    logic [ADDR_W-1:0] offset_q;
    logic [ILV_W-1:0]  ilv_clamped;

    // Clamp the requested interleave factor.
    always_comb ilv_clamped = ILV_W'(clamp_ilv(32'(ilv_in), MAX_ILV));

    // Capture the configuration on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_base   <= '0;
            col_base_q <= '0;
            stride     <= '0;
            offset_q   <= '0;
            ilv_eff    <= ILV_W'(1);
        end else if (load) begin
            row_base   <= row_base_in;
            col_base_q <= col_base_in;
            stride     <= stride_in;
            offset_q   <= offset_in;
            ilv_eff    <= ilv_clamped;
        end
    end

    // Start of the column group: base plus group offset.
    always_comb col_start = col_base_q + offset_q;

    assert_ilv_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ilv_eff != '0) && (32'(ilv_eff) <= MAX_ILV));

endmodule

// File: rtl/ilvag_slot_ctr.sv
// Round-robin slot counter for the interleave group. It steps on each
// advance, wraps after the last slot, and clears on configuration load.
// Assumes ilv_eff is at least 1 and at most 2**SLOT_W.
module ilvag_slot_ctr #(
    parameter int SLOT_W = 3,
    parameter int ILV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic [ILV_W-1:0]  ilv_eff,
    output logic [SLOT_W-1:0] slot_q,
    output logic              is_last
);
    // Last slot of the current group.
    always_comb is_last = (ILV_W'(slot_q) == ilv_eff - ILV_W'(1));

    // Step or clear the slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= '0;
        else if (load)
            slot_q <= '0;
        else if (adv)
            slot_q <= is_last ? '0 : slot_q + SLOT_W'(1);
    end

    assert_slot_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ILV_W'(slot_q) < ilv_eff);

    assert_stall_holds_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(slot_q));

    assert_load_clears_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (slot_q == '0));

endmodule

// File: rtl/ilvag_stream.sv
// One registered address stream: addr = base + mul*stride + add (mod 2^ADDR_W).
// The address register holds when en is low. The valid flag follows en.
// Assumes mul and add are already sized to fit below ADDR_W bits.
module ilvag_stream #(
    parameter int ADDR_W = 16,
    parameter int MUL_W  = 8,
    parameter int ADD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [MUL_W-1:0]  mul,
    input  logic [ADD_W-1:0]  add,
    output logic [ADDR_W-1:0] addr_q,
    output logic              vld_q
);
    logic [ADDR_W-1:0] addr_d;

    // Base-stride address arithmetic.
    always_comb addr_d = base + ADDR_W'(mul) * stride + ADDR_W'(add);

    // Register the address and the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= en;
            if (en)
                addr_q <= addr_d;
        end
    end

    assert_hold_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(addr_q));

endmodule

// File: rtl/ilv_addr_gen.sv
// Interleaved base-stride address generator (top). The row stream repeats
// one row element across the interleave group. The column stream walks
// one column per slot, round-robin. Assumes the loop unit keeps
// inner_cnt steady for a whole group and steps it after col_last.
module ilv_addr_gen #(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 8,
    parameter int MAX_ILV = 7,
    parameter int ILV_W   = $clog2(MAX_ILV) + 1,
    parameter int SLOT_W  = (MAX_ILV > 1) ? $clog2(MAX_ILV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_row_base,
    input  logic [ADDR_W-1:0] cfg_col_base,
    input  logic [ADDR_W-1:0] cfg_stride,
    input  logic [ADDR_W-1:0] cfg_offset,
    input  logic [ILV_W-1:0]  cfg_ilv,
    input  logic [CNT_W-1:0]  outer_cnt,
    input  logic [CNT_W-1:0]  inner_cnt,
    input  logic              advance,
    output logic [ADDR_W-1:0] row_addr,
    output logic              row_valid,
    output logic [ADDR_W-1:0] col_addr,
    output logic              col_valid,
    output logic [SLOT_W-1:0] col_tag,
    output logic              col_last
);
    logic [ADDR_W-1:0] row_base;
    logic [ADDR_W-1:0] col_start;
    logic [ADDR_W-1:0] stride;
    logic [ILV_W-1:0]  ilv_eff;
    logic [SLOT_W-1:0] slot_q;
    logic              slot_last;
    logic              step_en;

    // A load wins over an advance.
    always_comb step_en = advance && !cfg_load;

    ilvag_cfg_regs #(.ADDR_W(ADDR_W), .MAX_ILV(MAX_ILV), .ILV_W(ILV_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(cfg_load),
        .row_base_in(cfg_row_base), .col_base_in(cfg_col_base),
        .stride_in(cfg_stride), .offset_in(cfg_offset), .ilv_in(cfg_ilv),
        .row_base(row_base), .col_start(col_start), .stride(stride),
        .ilv_eff(ilv_eff)
    );

    ilvag_slot_ctr #(.SLOT_W(SLOT_W), .ILV_W(ILV_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .load(cfg_load), .adv(advance),
        .ilv_eff(ilv_eff), .slot_q(slot_q), .is_last(slot_last)
    );

    // Row stream: row index scales the stride, element index adds.
    ilvag_stream #(.ADDR_W(ADDR_W), .MUL_W(CNT_W), .ADD_W(CNT_W)) u_row (
        .clk(clk), .rst_n(rst_n), .en(step_en),
        .base(row_base), .stride(stride), .mul(outer_cnt), .add(inner_cnt),
        .addr_q(row_addr), .vld_q(row_valid)
    );

    // Column stream: element index scales the stride, slot adds.
    ilvag_stream #(.ADDR_W(ADDR_W), .MUL_W(CNT_W), .ADD_W(SLOT_W)) u_col (
        .clk(clk), .rst_n(rst_n), .en(step_en),
        .base(col_start), .stride(stride), .mul(inner_cnt), .add(slot_q),
        .addr_q(col_addr), .vld_q(col_valid)
    );

    // Register the slot tag and the last flag alongside the column address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_tag  <= '0;
            col_last <= 1'b0;
        end else if (step_en) begin
            col_tag  <= slot_q;
            col_last <= slot_last;
        end
    end

    assert_tag_sequence_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && $past(col_valid) && col_tag != '0)
            |-> (col_tag == SLOT_W'($past(col_tag) + SLOT_W'(1))));

    assert_last_matches_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |-> (col_last == (ILV_W'(col_tag) == ilv_eff - ILV_W'(1))));

    assert_load_blocks_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (!col_valid && !row_valid));

    assert_stall_no_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> (!col_valid && !row_valid));

endmodule

// File: tb/tb_ilv_addr_gen.sv
// Self-checking bench: directed corner cases plus seeded random groups.
module tb_ilv_addr_gen;
    localparam int ADDR_W = 16, CNT_W = 8, MAX_ILV = 7;
    localparam int ILV_W = $clog2(MAX_ILV) + 1;
    localparam int SLOT_W = $clog2(MAX_ILV);

    logic clk = 1'b0, rst_n = 1'b0, cfg_load = 1'b0, advance = 1'b0;
    logic [ADDR_W-1:0] cfg_row_base = '0, cfg_col_base = '0, cfg_stride = '0, cfg_offset = '0;
    logic [ILV_W-1:0]  cfg_ilv = '0;
    logic [CNT_W-1:0]  outer_cnt = '0, inner_cnt = '0;
    logic [ADDR_W-1:0] row_addr, col_addr;
    logic row_valid, col_valid, col_last;
    logic [SLOT_W-1:0] col_tag;

    int checks = 0, errors = 0;
    int unsigned m_rb = 0, m_cb = 0, m_st = 0, m_off = 0, m_ilv = 1, m_slot = 0;
    int unsigned h_row = 0, h_col = 0, h_tag = 0, h_last = 0;

    always #5 clk = ~clk;

    ilv_addr_gen dut (.*);

    task automatic chk(string req, int unsigned act, int unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int unsigned exp_row(int unsigned o, int unsigned i);
        return (m_rb + o * m_st + i) & 32'hFFFF;
    endfunction

    function automatic int unsigned exp_col(int unsigned i, int unsigned s);
        return (m_cb + m_off + s + i * m_st) & 32'hFFFF;
    endfunction

    function automatic int unsigned clampf(int unsigned r);
        return (r == 0) ? 1 : ((r > MAX_ILV) ? MAX_ILV : r);
    endfunction

    // One cycle with or without advance; checks the registered outputs.
    task automatic step(bit adv, int unsigned o, int unsigned i, string req);
        @(negedge clk);
        advance = adv; outer_cnt = CNT_W'(o); inner_cnt = CNT_W'(i);
        @(posedge clk); #1;
        if (adv) begin
            h_row = exp_row(o, i); h_col = exp_col(i, m_slot);
            h_tag = m_slot; h_last = (m_slot == m_ilv - 1) ? 1 : 0;
            m_slot = (m_slot == m_ilv - 1) ? 0 : m_slot + 1;
            chk({req, "/R2 row_valid"}, row_valid, 1);
            chk({req, "/R4 col_valid"}, col_valid, 1);
        end else begin
            chk({req, "/R6 row_valid"}, row_valid, 0);
            chk({req, "/R6 col_valid"}, col_valid, 0);
        end
        chk({req, "/R2 row_addr"}, row_addr, h_row);
        chk({req, "/R4 col_addr"}, col_addr, h_col);
        chk({req, "/R5 col_tag"}, col_tag, h_tag);
        chk({req, "/R5 col_last"}, col_last, h_last);
        @(negedge clk); advance = 1'b0;
    endtask

    // Load a configuration while also raising advance (R7 priority).
    task automatic load(int unsigned rb, int unsigned cb, int unsigned st,
                        int unsigned off, int unsigned ilv);
        @(negedge clk);
        cfg_load = 1'b1; advance = 1'b1;
        cfg_row_base = ADDR_W'(rb); cfg_col_base = ADDR_W'(cb);
        cfg_stride = ADDR_W'(st); cfg_offset = ADDR_W'(off); cfg_ilv = ILV_W'(ilv);
        @(posedge clk); #1;
        chk("R7 valid after load", {31'd0, col_valid | row_valid}, 0);
        chk("R7 tag held on load", col_tag, h_tag);
        @(negedge clk); cfg_load = 1'b0; advance = 1'b0;
        m_rb = rb & 32'hFFFF; m_cb = cb & 32'hFFFF; m_st = st & 32'hFFFF;
        m_off = off & 32'hFFFF; m_ilv = clampf(ilv); m_slot = 0;
    endtask

    // Run whole groups over a set of element indices.
    task automatic run_groups(int unsigned o, int unsigned nk, bit stalls, string req);
        for (int k = 0; k < int'(nk); k++) begin
            for (int s = 0; s < int'(m_ilv); s++) begin
                if (stalls && ($urandom % 4 == 0))
                    step(1'b0, $urandom % 256, $urandom % 256, "R6 stall");
                step(1'b1, o, k, req);
                if (s > 0) chk("R3 row address repeat", row_addr, exp_row(o, k));
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 row_valid", row_valid, 0);
        chk("R1 col_valid", col_valid, 0);
        chk("R1 row_addr", row_addr, 0);
        chk("R1 col_addr", col_addr, 0);
        chk("R1 col_tag", col_tag, 0);
        chk("R1 col_last", col_last, 0);
        step(1'b1, 3, 2, "R1 default factor");
        chk("R1 first tag", col_tag, 0);
        chk("R1 first last", col_last, 1);

        // R2 R3 R4 R5 full factor of 7
        load(100, 4000, 20, 7, 7);
        run_groups(2, 3, 1'b0, "R4 ilv7");

        // R6: stall mid-group, changed counters, then continue
        load(10, 500, 9, 0, 5);
        step(1'b1, 1, 0, "R6 pre");
        step(1'b1, 1, 0, "R6 pre");
        step(1'b0, 77, 44, "R6 stall");
        step(1'b0, 12, 3, "R6 stall");
        step(1'b1, 1, 0, "R6 resume");
        chk("R6 resume slot", col_tag, 2);

        // R7: load mid-group resets the slot
        step(1'b1, 1, 0, "R7 pre");
        load(10, 500, 9, 0, 5);
        step(1'b1, 1, 1, "R7 post");
        chk("R7 slot cleared", col_tag, 0);

        // R8: clamp 0 -> 1 and 12 -> 7
        load(0, 0, 3, 0, 0);
        run_groups(0, 3, 1'b0, "R8 zero");
        chk("R8 zero factor last", col_last, 1);
        load(0, 0, 3, 0, 12);
        run_groups(1, 2, 1'b0, "R8 big");
        chk("R8 big factor last tag", col_tag, MAX_ILV - 1);

        // R9: remainder group of 2 columns at offset 14
        load(0, 1000, 16, 14, 2);
        run_groups(4, 4, 1'b0, "R9 rem");
        chk("R9 rem wrap tag", col_tag, 1);

        // Random configurations with stalls, including address wrap
        for (int n = 0; n < 12; n++) begin
            load($urandom, $urandom, $urandom % 4096, $urandom % 256, $urandom % 9);
            run_groups($urandom % 256, 1 + $urandom % 4, 1'b1, "R2 random");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule